// File: doc/BRIEF.md
# Multi-Phase Period Synthesizer Phase-Select Controller

This block is the digital heart of a period synthesizer driven by K equally spaced copies of a reference clock. An outside circuit feeds the selected clock phase back in, and every rising edge of that phase is presented to the block as one output event (`adv`). On each event a split accumulator adds the control word. The integer part of the accumulator is the index of the next clock phase to select. A toggle flop flips on every event and gives the squarewave output. The phase generator and the glitch-free multiplexer that acts on the index sit outside the block.

The accumulator has a fractional part and an integer part. The fractional part works as a first-order noise shaper: its overflow carry goes to the carry input of the integer part. When shuffling is enabled, the carries are gathered in blocks of eight. Each block is released during the following block in an order chosen by a linear feedback shift register. The number of ones released per block is unchanged, so the average period holds while the short-term pattern is dithered. Turning shuffling off clears the buffered carries, and the integer part then takes the carries in their natural order. In that mode the block behaves exactly like one accumulator on the combined word. The integer word must be at least one for every event to move to a new phase.

Top module: `fa_phase_ctrl`

## Requirements
- R1: While `rst_n` is low, `phase_sel` is 0 and `sq_out` is 0. Both accumulator parts and the toggle flop start from zero.
- R2: A cycle with `adv` low changes neither `phase_sel` nor `sq_out`.
- R3: Each cycle with `adv` high inverts `sq_out`, so after n events `sq_out` equals n mod 2.
- R4: With `shuffle_en` low, after n events `phase_sel` = floor(n·W / 2^FRAC_BITS) mod 2^PHASE_BITS, where W = `int_word`·2^FRAC_BITS + `frac_word`.
- R5: With `shuffle_en` high, each event moves `phase_sel` forward by `int_word` or `int_word`+1, modulo 2^PHASE_BITS.
- R6: With `shuffle_en` high since reset, at the end of the m-th block of 8 events (m ≥ 1), `phase_sel` = (8·m·`int_word` + floor(8·(m−1)·`frac_word` / 2^FRAC_BITS)) mod 2^PHASE_BITS. Each block releases exactly the ones count of the block before it.
- R7: With `shuffle_en` high, no carry reaches the integer part during the first block after reset, so after n ≤ 8 events `phase_sel` = n·`int_word` mod 2^PHASE_BITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one rising edge per possible event |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| adv | input | 1 | Output event strobe: advance the accumulator this cycle |
| int_word | input | PHASE_BITS | Integer part of the control word |
| frac_word | input | FRAC_BITS | Fractional part of the control word |
| shuffle_en | input | 1 | Route fractional carries through the block reorder buffer |
| phase_sel | output | PHASE_BITS | Index of the clock phase to select |
| sq_out | output | 1 | Toggle (squarewave) output |

## Verification
Every result is registered. `phase_sel` and `sq_out` show the effect of an event in the cycle after the edge that sampled `adv` high. The bench drives inputs and samples outputs on falling edges, so each sample reflects exactly the events counted up to the previous rising edge. Expected values come from the event count alone. Block totals under shuffling are checked only at counts that are multiples of eight, because the order inside a block is pseudo-random while the total is fixed. Step sizes are checked at every event.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int DEF_PHASE_BITS = 3;
  localparam int DEF_FRAC_BITS  = 5;
  localparam int DEF_BLOCK_LOG  = 3;
  localparam int DEF_LFSR_W     = 8;
  localparam logic [7:0] DEF_LFSR_TAPS = 8'hB8;
  localparam logic [7:0] DEF_LFSR_SEED = 8'h5A;
endpackage

// File: rtl/fa_frac_acc.sv
module fa_frac_acc #(
  parameter int FRAC_BITS = fa_pkg::DEF_FRAC_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic [FRAC_BITS-1:0] frac_word,
  output logic                 carry
);
  logic [FRAC_BITS-1:0] frac_q, frac_d;
  logic [FRAC_BITS:0]   sum;

  always_comb begin
    sum    = {1'b0, frac_q} + {1'b0, frac_word};
    carry  = sum[FRAC_BITS];
    frac_d = frac_q;
    if (adv) frac_d = sum[FRAC_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frac_q <= '0;
    else        frac_q <= frac_d;
  end
endmodule

// File: rtl/fa_lfsr.sv
module fa_lfsr #(
  parameter int              WIDTH = fa_pkg::DEF_LFSR_W,
  parameter logic [WIDTH-1:0] TAPS = WIDTH'(fa_pkg::DEF_LFSR_TAPS),
  parameter logic [WIDTH-1:0] SEED = WIDTH'(fa_pkg::DEF_LFSR_SEED)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [WIDTH-1:0] state
);
  logic [WIDTH-1:0] state_d;

  always_comb begin
    state_d = state;
    if (step) state_d = {state[WIDTH-2:0], ^(state & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= state_d;
  end
endmodule

// File: rtl/fa_carry_shuffle.sv
module fa_carry_shuffle #(
  parameter int BLOCK_LOG = fa_pkg::DEF_BLOCK_LOG,
  parameter int LFSR_W    = fa_pkg::DEF_LFSR_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic enable,
  input  logic carry_in,
  output logic carry_out
);
  localparam int BLOCK = 1 << BLOCK_LOG;

  logic [BLOCK_LOG-1:0] cnt_q, cnt_d;
  logic [BLOCK_LOG-1:0] start_q, start_d;
  logic [BLOCK_LOG-1:0] stride_q, stride_d;
  logic [BLOCK_LOG-1:0] slot;
  logic [BLOCK-1:0]     coll_q, coll_d, coll_set;
  logic [BLOCK-1:0]     rel_q, rel_d;
  logic [LFSR_W-1:0]    lfsr_state;
  logic                 block_end;
  logic                 lfsr_step;

  fa_lfsr #(.WIDTH(LFSR_W)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (lfsr_step),
    .state (lfsr_state)
  );

  assign block_end = &cnt_q;
  assign lfsr_step = enable && adv && block_end;
  assign slot      = start_q + cnt_q * stride_q;
  assign carry_out = enable ? rel_q[slot] : carry_in;

  always_comb begin
    coll_set       = coll_q;
    coll_set[cnt_q] = carry_in;
    cnt_d    = cnt_q;
    coll_d   = coll_q;
    rel_d    = rel_q;
    start_d  = start_q;
    stride_d = stride_q;
    if (!enable) begin
      cnt_d    = '0;
      coll_d   = '0;
      rel_d    = '0;
      start_d  = '0;
      stride_d = BLOCK_LOG'(1);
    end else if (adv) begin
      cnt_d  = cnt_q + 1'b1;
      coll_d = coll_set;
      if (block_end) begin
        rel_d    = coll_set;
        coll_d   = '0;
        start_d  = lfsr_state[BLOCK_LOG-1:0] ^ lfsr_state[LFSR_W-1 -: BLOCK_LOG];
        stride_d = {lfsr_state[BLOCK_LOG +: BLOCK_LOG-1], 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      coll_q   <= '0;
      rel_q    <= '0;
      start_q  <= '0;
      stride_q <= BLOCK_LOG'(1);
    end else begin
      cnt_q    <= cnt_d;
      coll_q   <= coll_d;
      rel_q    <= rel_d;
      start_q  <= start_d;
      stride_q <= stride_d;
    end
  end

  // Checker state: ones released so far in the current block.
  logic [BLOCK_LOG:0] rel_ones_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   rel_ones_q <= '0;
    else if (!enable)             rel_ones_q <= '0;
    else if (adv && block_end)    rel_ones_q <= '0;
    else if (adv)                 rel_ones_q <= rel_ones_q + {{BLOCK_LOG{1'b0}}, carry_out};
  end

  AST_BLOCK_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && adv && block_end) |->
      (int'(rel_ones_q) + int'(carry_out) == $countones(rel_q))); // R6
endmodule

// File: rtl/fa_int_acc.sv
module fa_int_acc #(
  parameter int PHASE_BITS = fa_pkg::DEF_PHASE_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv,
  input  logic [PHASE_BITS-1:0] int_word,
  input  logic                  carry,
  output logic [PHASE_BITS-1:0] int_q
);
  logic [PHASE_BITS-1:0] int_d;

  always_comb begin
    int_d = int_q;
    if (adv) int_d = int_q + int_word + PHASE_BITS'(carry);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_q <= '0;
    else        int_q <= int_d;
  end
endmodule

// File: rtl/fa_phase_ctrl.sv
module fa_phase_ctrl #(
  parameter int PHASE_BITS = fa_pkg::DEF_PHASE_BITS,
  parameter int FRAC_BITS  = fa_pkg::DEF_FRAC_BITS,
  parameter int BLOCK_LOG  = fa_pkg::DEF_BLOCK_LOG,
  parameter int LFSR_W     = fa_pkg::DEF_LFSR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv,
  input  logic [PHASE_BITS-1:0] int_word,
  input  logic [FRAC_BITS-1:0]  frac_word,
  input  logic                  shuffle_en,
  output logic [PHASE_BITS-1:0] phase_sel,
  output logic                  sq_out
);
  logic frac_carry;
  logic int_carry;
  logic sq_d;

  fa_frac_acc #(.FRAC_BITS(FRAC_BITS)) u_frac (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .frac_word (frac_word),
    .carry     (frac_carry)
  );

  fa_carry_shuffle #(.BLOCK_LOG(BLOCK_LOG), .LFSR_W(LFSR_W)) u_shuffle (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .enable    (shuffle_en),
    .carry_in  (frac_carry),
    .carry_out (int_carry)
  );

  fa_int_acc #(.PHASE_BITS(PHASE_BITS)) u_int (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .int_word (int_word),
    .carry    (int_carry),
    .int_q    (phase_sel)
  );

  always_comb begin
    sq_d = sq_out;
    if (adv) sq_d = ~sq_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sq_out <= 1'b0;
    else        sq_out <= sq_d;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(phase_sel) && $stable(sq_out))); // R2

  AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (sq_out != $past(sq_out))); // R3

  AST_NATURAL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !shuffle_en) |=>
      (phase_sel == PHASE_BITS'($past(phase_sel) + $past(int_word)
                                + PHASE_BITS'($past(frac_carry))))); // R4

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && shuffle_en) |=>
      (PHASE_BITS'(phase_sel - $past(phase_sel) - $past(int_word)) <= PHASE_BITS'(1))); // R5
endmodule

// File: tb/fa_phase_ctrl_tb.sv
module fa_phase_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PB = 3;
  localparam int FB = 5;
  localparam int STEPS = 48;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          adv;
  logic [PB-1:0] int_word;
  logic [FB-1:0] frac_word;
  logic          shuffle_en;
  logic [PB-1:0] phase_sel;
  logic          sq_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  fa_phase_ctrl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (adv),
    .int_word   (int_word),
    .frac_word  (frac_word),
    .shuffle_en (shuffle_en),
    .phase_sel  (phase_sel),
    .sq_out     (sq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (I=%0d F=%0d sh=%0d)",
               req, act, exp, int_word, frac_word, shuffle_en);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int flist [6] = '{0, 1, 5, 16, 27, 31};
    rst_n = 1'b0; adv = 1'b0; int_word = '0; frac_word = '0; shuffle_en = 1'b0;
    @(negedge clk);
    for (int s = 0; s < 2; s++) begin
      for (int ii = 0; ii < 8; ii++) begin
        for (int fi = 0; fi < 6; fi++) begin
          int n;
          logic [PB-1:0] prev_ph;
          logic prev_sq;
          int w;
          rst_n = 1'b0; adv = 1'b0;
          int_word = PB'(ii); frac_word = FB'(flist[fi]); shuffle_en = s[0];
          @(negedge clk);
          // R1: reset state
          chk(phase_sel == 0, "R1 phase_sel", int'(phase_sel), 0);
          chk(sq_out == 1'b0, "R1 sq_out", int'(sq_out), 0);
          rst_n = 1'b1;
          @(negedge clk);
          n = 0;
          w = ii * 32 + flist[fi];
          for (int st = 0; st < STEPS; st++) begin
            bit a;
            chk(int'(sq_out) == (n & 1), "R3 parity", int'(sq_out), n & 1);
            if (s == 0) begin
              chk(int'(phase_sel) == (((n * w) >> FB) & 7), "R4 natural",
                  int'(phase_sel), ((n * w) >> FB) & 7);
            end else begin
              if (n <= 8)
                chk(int'(phase_sel) == ((n * ii) & 7), "R7 first block",
                    int'(phase_sel), (n * ii) & 7);
              if (n > 0 && (n % 8) == 0) begin
                int m, e;
                m = n / 8;
                e = (8 * m * ii + (8 * (m - 1) * flist[fi]) / 32) & 7;
                chk(int'(phase_sel) == e, "R6 block total", int'(phase_sel), e);
              end
            end
            a = ((st % 5) != 4);
            adv = a;
            prev_ph = phase_sel;
            prev_sq = sq_out;
            @(posedge clk);
            if (a) n++;
            @(negedge clk);
            adv = 1'b0;
            if (!a) begin
              chk(phase_sel == prev_ph, "R2 hold phase", int'(phase_sel), int'(prev_ph));
              chk(sq_out == prev_sq, "R2 hold sq", int'(sq_out), int'(prev_sq));
            end else begin
              chk(sq_out == ~prev_sq, "R3 toggle", int'(sq_out), int'(~prev_sq));
              if (s == 1) begin
                int d;
                d = (int'(phase_sel) - int'(prev_ph) - ii) & 7;
                chk(d <= 1, "R5 step", d, 1);
              end
            end
          end
        end
      end
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule